// File: doc/BRIEF.md
# Continual Pilot Position Generator

This block produces the subcarrier indices of the continual pilots of one OFDM symbol, in ascending order, one index per request. It does not hold a table of absolute indices. It stores only the spacing between neighbouring pilots for one period of a pattern that repeats across the symbol. A running-sum accumulator turns these spacings back into absolute indices.

A symbol begins with a one-cycle start pulse. In the next cycle the generator presents index 0 with its valid flag raised. Each request that is accepted adds the next stored spacing to the running sum. The spacing table is a constant ROM of 64 entries, each 8 bits wide. Only the first 45 entries are used, and the read address wraps from entry 44 back to entry 0. When the 177th index is on the output, the last flag rises and further requests have no effect until the next start.

The spacing held in table entry k (k from 0 to 44) is a fixed function of the pattern: 16 + ((13·k + 5) mod 45). Entries 45 to 63 hold 0 and are never read.

Top module: `pilot_pos_gen`

## Requirements
- R1: After reset, pos_valid, pos_last and pos_pos are all 0.
- R2: A sym_start pulse makes the next cycle show pos_valid=1, pos_pos=0 and pos_last=0.
- R3: A pos_req taken while pos_valid=1 and pos_last=0 (and sym_start=0) advances pos_pos in the next cycle. The n-th accepted request (n from 0) adds the spacing in table entry n mod 45.
- R4: Table entry k holds 16 + ((13·k + 5) mod 45) as an 8-bit value. Only entries 0 to 44 are addressed, and the address wraps from 44 to 0 while the sum keeps running.
- R5: pos_last goes high exactly when the 177th index (after 176 accepted requests) is on the output. That index is 6661.
- R6: A pos_req while pos_last=1 is ignored: pos_pos, pos_valid and pos_last stay unchanged.
- R7: A pos_req before any sym_start is ignored: pos_valid stays 0.
- R8: A sym_start in the middle of a symbol restarts the sequence at index 0, and sym_start wins over a pos_req in the same cycle.
- R9: While no pos_req is given, pos_pos holds its value.
- R10: The indices rise strictly and fit in 13 bits without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_start | input | 1 | One-cycle pulse that opens a new symbol |
| pos_req | input | 1 | Request for the next pilot index |
| pos_pos | output | 13 | Current pilot subcarrier index |
| pos_valid | output | 1 | pos_pos holds a generated index |
| pos_last | output | 1 | pos_pos is the final index of the symbol |

## Verification
The bench builds the block with its default parameters: 177 pilots, a period of 45 and a 64-entry ROM. With these values a full symbol wraps the table address three times and then stops partway through the fourth pass, 41 entries in. This exercises the wrap of the address while the sum keeps running, and the stop on the final index away from a period boundary. It also checks that the unused upper ROM entries are never reached, and that the final index sits close to the 13-bit limit.

// File: rtl/pilot_gap_pkg.sv
package pilot_gap_pkg;

  // Spacing between pilot k and pilot k+1 within one period of the pattern.
  function automatic int unsigned gap_value(input int unsigned k,
                                            input int unsigned period,
                                            input int unsigned base,
                                            input int unsigned stride,
                                            input int unsigned offset);
    return base + ((stride * k + offset) % period);
  endfunction

  // Address that follows a in a table read cyclically over `period` entries.
  function automatic int unsigned next_addr(input int unsigned a,
                                            input int unsigned period);
    return (a == period - 1) ? 0 : a + 1;
  endfunction

endpackage

// File: rtl/pilot_gap_rom.sv
module pilot_gap_rom #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned PERIOD = 45,
  parameter int unsigned GAP_W  = 8,
  parameter int unsigned BASE   = 16,
  parameter int unsigned STRIDE = 13,
  parameter int unsigned OFFSET = 5,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr,
  output logic [GAP_W-1:0] rd_gap
);

  logic [GAP_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    if (g < PERIOD) begin : g_used
      localparam int unsigned GV =
        pilot_gap_pkg::gap_value(g, PERIOD, BASE, STRIDE, OFFSET);
      assign tbl[g] = GAP_W'(GV);
    end else begin : g_spare
      assign tbl[g] = '0;
    end
  end

  assign rd_gap = tbl[rd_addr];

  AST_GAP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_addr) < PERIOD) |-> (rd_gap != '0)); // R4

endmodule

// File: rtl/pilot_seq_ctrl.sv
module pilot_seq_ctrl #(
  parameter int unsigned NUM_PILOTS = 177,
  parameter int unsigned PERIOD     = 45,
  parameter int unsigned DEPTH      = 64,
  localparam int unsigned AW        = $clog2(DEPTH),
  localparam int unsigned CW        = $clog2(NUM_PILOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_start,
  input  logic          pos_req,
  output logic [AW-1:0] rom_addr,
  output logic          running,
  output logic          at_last,
  output logic          adv_evt,
  output logic          wrap_evt
);

  localparam logic [CW-1:0] LAST_CNT = CW'(NUM_PILOTS - 1);
  localparam logic [AW-1:0] LAST_ADR = AW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  assign at_last  = running && (cnt == LAST_CNT);
  assign adv_evt  = running && pos_req && !at_last && !sym_start;
  assign wrap_evt = adv_evt && (rom_addr == LAST_ADR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      cnt      <= '0;
      rom_addr <= '0;
    end else if (sym_start) begin
      running  <= 1'b1;
      cnt      <= '0;
      rom_addr <= '0;
    end else if (adv_evt) begin
      cnt      <= cnt + 1'b1;
      rom_addr <= AW'(pilot_gap_pkg::next_addr(32'(rom_addr), PERIOD));
    end
  end

  AST_ADDR_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rom_addr) < PERIOD); // R4
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (rom_addr == '0) && running); // R4
  AST_HOLD_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && !sym_start) |=> at_last && $stable(rom_addr)); // R6
  AST_IDLE_UNTIL_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !sym_start) |=> !running); // R7

endmodule

// File: rtl/pilot_pos_acc.sv
module pilot_pos_acc #(
  parameter int unsigned POS_W = 13,
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [GAP_W-1:0] gap,
  output logic [POS_W-1:0] pos,
  output logic             ovf_evt
);

  logic [POS_W:0] sum;

  assign sum     = {1'b0, pos} + {{(POS_W + 1 - GAP_W){1'b0}}, gap};
  assign ovf_evt = adv && sum[POS_W];

  always_ff @(posedge clk) begin
    if (!rst_n)      pos <= '0;
    else if (clear)  pos <= '0;
    else if (adv)    pos <= sum[POS_W-1:0];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_evt); // R10
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pos == '0)); // R2

endmodule

// File: rtl/pilot_pos_gen.sv
module pilot_pos_gen #(
  parameter int unsigned NUM_PILOTS = 177,
  parameter int unsigned PERIOD     = 45,
  parameter int unsigned ROM_DEPTH  = 64,
  parameter int unsigned GAP_W      = 8,
  parameter int unsigned POS_W      = 13,
  parameter int unsigned GAP_BASE   = 16,
  parameter int unsigned GAP_STRIDE = 13,
  parameter int unsigned GAP_OFFSET = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_start,
  input  logic             pos_req,
  output logic [POS_W-1:0] pos_pos,
  output logic             pos_valid,
  output logic             pos_last
);

  localparam int unsigned AW = $clog2(ROM_DEPTH);

  logic [AW-1:0]    rom_addr;
  logic [GAP_W-1:0] cur_gap;
  logic             adv_evt;
  logic             wrap_evt;
  logic             ovf_evt;

  pilot_seq_ctrl #(
    .NUM_PILOTS (NUM_PILOTS),
    .PERIOD     (PERIOD),
    .DEPTH      (ROM_DEPTH)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_start (sym_start),
    .pos_req   (pos_req),
    .rom_addr  (rom_addr),
    .running   (pos_valid),
    .at_last   (pos_last),
    .adv_evt   (adv_evt),
    .wrap_evt  (wrap_evt)
  );

  pilot_gap_rom #(
    .DEPTH  (ROM_DEPTH),
    .PERIOD (PERIOD),
    .GAP_W  (GAP_W),
    .BASE   (GAP_BASE),
    .STRIDE (GAP_STRIDE),
    .OFFSET (GAP_OFFSET)
  ) u_rom (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (rom_addr),
    .rd_gap  (cur_gap)
  );

  pilot_pos_acc #(
    .POS_W (POS_W),
    .GAP_W (GAP_W)
  ) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (sym_start),
    .adv     (adv_evt),
    .gap     (cur_gap),
    .pos     (pos_pos),
    .ovf_evt (ovf_evt)
  );

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    sym_start |=> pos_valid && (pos_pos == '0) && !pos_last); // R2
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (pos_pos > $past(pos_pos))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_valid && !pos_req && !sym_start) |=> $stable(pos_pos) && pos_valid); // R9
  AST_LAST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_last && pos_req && !sym_start) |=> $stable(pos_pos) && pos_last); // R6
  AST_WRAP_IS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> adv_evt && !ovf_evt); // R4

endmodule

// File: tb/pilot_pos_gen_tb.sv
module pilot_pos_gen_tb;

  localparam int NP = 177;

  typedef struct {
    logic        valid;
    logic [12:0] pos;
    logic        last;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sym_start = 1'b0;
  logic        pos_req = 1'b0;
  logic [12:0] pos_pos;
  logic        pos_valid;
  logic        pos_last;

  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;
  exp_t q[$];
  exp_t e;

  // bench model state
  logic        m_valid = 0;
  int          m_pos   = 0;
  int          m_idx   = 0;

  always #10 clk = ~clk;

  pilot_pos_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_start (sym_start),
    .pos_req   (pos_req),
    .pos_pos   (pos_pos),
    .pos_valid (pos_valid),
    .pos_last  (pos_last)
  );

  // Spacing for step n, walked residue by residue (R4).
  function automatic int model_gap(input int n);
    int r = 5;
    for (int i = 0; i < (n % 45); i++) r = (r + 13) % 45;
    return 16 + r;
  endfunction

  task automatic check(input string tag, input logic v, input int p, input logic l);
    n_chk++;
    if (pos_valid !== v || pos_pos !== 13'(p) || pos_last !== l) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b pos=%0d last=%0b, expected valid=%0b pos=%0d last=%0b",
               tag, pos_valid, pos_pos, pos_last, v, p, l);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outcome
  task automatic step(input logic s, input logic r, input string tag);
    exp_t x;
    @(negedge clk);
    sym_start = s;
    pos_req   = r;
    if (s) begin
      m_valid = 1; m_pos = 0; m_idx = 0;
    end else if (r && m_valid && m_idx != NP - 1) begin
      m_pos = m_pos + model_gap(m_idx);
      m_idx++;
    end
    x.valid = m_valid;
    x.pos   = 13'(m_pos);
    x.last  = m_valid && (m_idx == NP - 1);
    x.tag   = tag;
    q.push_back(x);
  endtask

  // monitor: compares after each clock edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.tag, e.valid, int'(e.pos), e.last);
    end
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b0, 0, 1'b0);
    rst_n = 1'b1;
    step(0, 1, "R7 req before start");
    step(0, 1, "R7 req before start");
    step(1, 0, "R2 start");
    step(0, 0, "R9 hold");
    step(0, 1, "R3 first step");
    step(0, 0, "R9 hold");
    step(0, 0, "R9 hold");
    for (int i = 0; i < 48; i++) step(0, 1, "R3 step across wrap R4");
    step(1, 1, "R8 start over req");
    step(0, 0, "R8 after restart");
    for (int i = 0; i < NP - 1; i++) step(0, 1, (i == NP - 2) ? "R5 final" : "R3 R10 step");
    for (int i = 0; i < 4; i++) step(0, 1, "R6 req after last");
    step(0, 0, "R6 idle after last");
    repeat (2) @(posedge clk);
    #6;
    check("R5 final index 6661", 1'b1, 6661, 1'b1);
    step(1, 0, "R2 restart after last");
    step(0, 1, "R3 first step again");
    step(0, 0, "R9 hold");
    repeat (2) @(posedge clk);
    #6;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule